// File: doc/BRIEF.md
# Wrapping Page Write Staging Buffer

This block gathers the data bytes of a single write transaction on a serial memory bus and hands them to the backing store as one commit. A bus sequencer opens a transaction with a start address and a target. The target is either the byte array or the control-register space. The sequencer then strobes each data byte once that byte and its acknowledge are complete. It closes the transaction with a stop, or with an abort when the stop fell inside a byte.

Incoming bytes land in a staging register that is as wide as the largest page, and each byte slot has its own dirty flag. The column address advances after each byte and wraps inside the current page, so a long burst overwrites its own earlier bytes. The page part of the address never moves during a transaction. A valid stop produces a one-cycle commit that carries the page base, the dirty mask and the staged bytes. The block always reports the running address pointer.

Top module: `wrap_page_stager`

## Requirements
- R1: After reset `commit_vld` is 0 and `ptr_out` is 0.
- R2: The page length is 16 bytes for the array target (`tgt_ctrl`=0) and 8 bytes for the control target (`tgt_ctrl`=1). `commit_addr` equals the start address with its low 4 (array) or 3 (control) bits cleared.
- R3: Each accepted byte is stored at the current column, and the column then advances by one. Past the last column of the page it wraps to column 0 of the same page. `ptr_out` is always the page base OR the current column. Example: 12 bytes from 0x20A fill columns 10..15 and then 0..5, and `ptr_out` ends at 0x206.
- R4: When more bytes arrive than the page holds, later bytes overwrite earlier ones in wrap order, so the last byte written to each column wins.
- R5: A stop after at least one accepted byte raises `commit_vld` for exactly one cycle, in the cycle after the stop is sampled. Bit i of `commit_mask` is set only for column i that was written. Byte i of `commit_data` (bits 8i+7..8i) holds that column's data.
- R6: A stop with no byte accepted since the transaction opened produces no commit.
- R7: An abort produces no commit and clears every dirty flag. A later stop without newly accepted bytes therefore commits nothing.
- R8: A control-target transaction whose page base equals `RTC_BASE` commits only when all 8 columns are dirty. Otherwise the stop discards it.
- R9: After a commit all dirty flags are clear. A further stop with no new bytes produces no commit.
- R10: A `byte_vld` that arrives in the same cycle as `txn_open`, `stop` or `abort` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_open | input | 1 | Opens a transaction and latches the start address and target |
| start_addr | input | ADDR_W | Start byte address |
| tgt_ctrl | input | 1 | 1 selects the control space (8-byte pages), 0 selects the array (16-byte pages) |
| byte_vld | input | 1 | A full data byte and its acknowledge were received |
| byte_data | input | 8 | The data byte |
| stop | input | 1 | Stop condition at a byte boundary |
| abort | input | 1 | Stop condition inside a byte |
| commit_vld | output | 1 | One-cycle commit request |
| commit_ctrl | output | 1 | Target of the commit |
| commit_addr | output | ADDR_W | Page base address of the commit |
| commit_mask | output | PAGE_ARR | Per-column write enables |
| commit_data | output | 8*PAGE_ARR | Staged bytes, column i at bits 8i+7..8i |
| ptr_out | output | ADDR_W | Running address pointer |

## Verification
Some properties can be judged from one or two cycles of state, and the embedded assertions check these on every cycle. A control transaction never reaches a column of 8 or more. A commit always carries a non-empty mask. A commit to the real-time page always carries a full mask. An abort is never followed by a commit, and a commit leaves the flags clear. Other behaviour depends on a whole transaction, and only the directed scenarios can show it: the exact wrap order, which byte survives an overflow, the final pointer value, and whether the committed image matches an image built independently from the requirements.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic {TGT_ARRAY = 1'b0, TGT_CTRL = 1'b1} tgt_e;

  // page length for a target, given the two configured lengths
  function automatic int page_len(tgt_e t, int arr_len, int ctl_len);
    return (t == TGT_CTRL) ? ctl_len : arr_len;
  endfunction
endpackage

// File: rtl/wpb_col_ctr.sv
module wpb_col_ctr
  import wpb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_ARR = 16,
  parameter int PAGE_CTL = 8,
  localparam int CW      = $clog2(PAGE_ARR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic [ADDR_W-1:0] start_addr,
  input  tgt_e              tgt,
  input  logic              adv,
  output logic [CW-1:0]     col,
  output logic [ADDR_W-1:0] base,
  output tgt_e              tgt_q,
  output logic [ADDR_W-1:0] ptr
);
  logic [CW-1:0]     col_q;
  logic [ADDR_W-1:0] base_q;

  function automatic logic [ADDR_W-1:0] lim_of(tgt_e t);
    return ADDR_W'(page_len(t, PAGE_ARR, PAGE_CTL) - 1);
  endfunction

  function automatic logic [CW-1:0] next_col(logic [CW-1:0] c, tgt_e t);
    logic [CW-1:0] n;
    n = c + 1'b1;
    return n & CW'(lim_of(t));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      base_q <= '0;
      tgt_q  <= TGT_ARRAY;
    end else if (open) begin
      tgt_q  <= tgt;
      base_q <= start_addr & ~lim_of(tgt);
      col_q  <= CW'(start_addr & lim_of(tgt));
    end else if (adv) begin
      col_q <= next_col(col_q, tgt_q);
    end
  end

  assign col  = col_q;
  assign base = base_q;
  assign ptr  = base_q | ADDR_W'(col_q);

  // R2
  ctl_col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == TGT_CTRL) |-> (col_q < CW'(PAGE_CTL)));
endmodule

// File: rtl/wpb_stage.sv
module wpb_stage #(
  parameter int NB = 16,
  localparam int CW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CW-1:0]   wcol,
  input  logic [7:0]      wdata,
  input  logic            clr,
  output logic [8*NB-1:0] data,
  output logic [NB-1:0]   dirty
);
  for (genvar g = 0; g < NB; g++) begin : g_slot
    logic [7:0] d_q;
    logic       f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        f_q <= 1'b0;
      end else if (clr) begin
        f_q <= 1'b0;
      end else if (wr && wcol == CW'(g)) begin
        d_q <= wdata;
        f_q <= 1'b1;
      end
    end
    assign data[8*g +: 8] = d_q;
    assign dirty[g]       = f_q;
  end
endmodule

// File: rtl/wpb_commit_gate.sv
module wpb_commit_gate
  import wpb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_ARR = 16,
  parameter int PAGE_CTL = 8,
  parameter logic [ADDR_W-1:0] RTC_BASE = 12'h030
) (
  input  logic              stop,
  input  logic              abort,
  input  tgt_e              tgt_q,
  input  logic [ADDR_W-1:0] base,
  input  logic [PAGE_ARR-1:0] dirty,
  output logic              go,
  output logic              discard
);
  logic rtc_hit, rtc_full, any;

  always_comb begin
    rtc_hit  = (tgt_q == TGT_CTRL) && (base == RTC_BASE);
    rtc_full = &dirty[PAGE_CTL-1:0];
    any      = |dirty;
    go       = stop && !abort && any && (!rtc_hit || rtc_full);
    discard  = abort || (stop && !go);
  end
endmodule

// File: rtl/wrap_page_stager.sv
module wrap_page_stager
  import wpb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_ARR = 16,
  parameter int PAGE_CTL = 8,
  parameter logic [ADDR_W-1:0] RTC_BASE = 12'h030,
  localparam int CW = $clog2(PAGE_ARR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  txn_open,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  tgt_ctrl,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_data,
  input  logic                  stop,
  input  logic                  abort,
  output logic                  commit_vld,
  output logic                  commit_ctrl,
  output logic [ADDR_W-1:0]     commit_addr,
  output logic [PAGE_ARR-1:0]   commit_mask,
  output logic [8*PAGE_ARR-1:0] commit_data,
  output logic [ADDR_W-1:0]     ptr_out
);
  tgt_e              tgt_q;
  logic [CW-1:0]     col;
  logic [ADDR_W-1:0] base;
  logic [PAGE_ARR-1:0] dirty;
  logic              accept, go, discard, commit_q, clr;

  assign accept = byte_vld && !txn_open && !stop && !abort;

  wpb_col_ctr #(.ADDR_W(ADDR_W), .PAGE_ARR(PAGE_ARR), .PAGE_CTL(PAGE_CTL)) u_col (
    .clk(clk), .rst_n(rst_n), .open(txn_open), .start_addr(start_addr),
    .tgt(tgt_e'(tgt_ctrl)), .adv(accept), .col(col), .base(base),
    .tgt_q(tgt_q), .ptr(ptr_out)
  );

  wpb_commit_gate #(.ADDR_W(ADDR_W), .PAGE_ARR(PAGE_ARR), .PAGE_CTL(PAGE_CTL),
                    .RTC_BASE(RTC_BASE)) u_gate (
    .stop(stop), .abort(abort), .tgt_q(tgt_q), .base(base), .dirty(dirty),
    .go(go), .discard(discard)
  );

  assign clr = txn_open || discard || commit_q;

  wpb_stage #(.NB(PAGE_ARR)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr(accept), .wcol(col), .wdata(byte_data),
    .clr(clr), .data(commit_data), .dirty(dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= go;
  end

  assign commit_vld  = commit_q;
  assign commit_ctrl = (tgt_q == TGT_CTRL);
  assign commit_addr = base;
  assign commit_mask = dirty;

  // R5
  commit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> (commit_mask != '0));

  // R5
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |=> !commit_vld);

  // R8
  rtc_full_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && commit_ctrl && commit_addr == RTC_BASE) |-> (&commit_mask[PAGE_CTL-1:0]));

  // R7
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !commit_vld);

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && !byte_vld) |=> (commit_mask == '0));

  // R2
  ctl_upper_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ctrl |-> (commit_mask[PAGE_ARR-1:PAGE_CTL] == '0));
endmodule

// File: tb/tb_wrap_page_stager.sv
module tb_wrap_page_stager;
  localparam int AW = 12;
  localparam int NB = 16;

  logic clk = 0, rst_n = 0;
  logic txn_open = 0, tgt_ctrl = 0, byte_vld = 0, stop = 0, abort = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic commit_vld, commit_ctrl;
  logic [AW-1:0] commit_addr, ptr_out;
  logic [NB-1:0] commit_mask;
  logic [8*NB-1:0] commit_data;

  always #4 clk = ~clk;

  wrap_page_stager dut (
    .clk(clk), .rst_n(rst_n), .txn_open(txn_open), .start_addr(start_addr),
    .tgt_ctrl(tgt_ctrl), .byte_vld(byte_vld), .byte_data(byte_data),
    .stop(stop), .abort(abort), .commit_vld(commit_vld), .commit_ctrl(commit_ctrl),
    .commit_addr(commit_addr), .commit_mask(commit_mask),
    .commit_data(commit_data), .ptr_out(ptr_out)
  );

  int vecs = 0, bad = 0, cyc = 0, s_cnt = 0;
  logic [NB-1:0]   s_mask;
  logic [8*NB-1:0] s_data;
  logic [AW-1:0]   s_addr;
  logic            s_ctrl;
  logic [NB-1:0]   e_mask;
  logic [7:0]      e_data [NB];

  always @(negedge clk) begin
    cyc++;
    if (commit_vld) begin
      s_cnt++; s_mask = commit_mask; s_data = commit_data;
      s_addr = commit_addr; s_ctrl = commit_ctrl;
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] val(int seed, int i);
    return 8'(seed + 7 * i);
  endfunction

  task automatic open_txn(logic [AW-1:0] a, logic c);
    @(negedge clk); txn_open = 1; start_addr = a; tgt_ctrl = c;
    @(negedge clk); txn_open = 0;
    s_cnt = 0;
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk); byte_vld = 1; byte_data = b;
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    @(negedge clk);
  endtask

  // bench's own image: column = (start + i) mod page length
  task automatic run_write(logic [AW-1:0] a, logic c, int n, int seed);
    int len = c ? 8 : 16;
    int col = int'(a) % len;
    e_mask = '0;
    for (int k = 0; k < NB; k++) e_data[k] = '0;
    open_txn(a, c);
    for (int i = 0; i < n; i++) begin
      put(val(seed, i));
      e_data[col] = val(seed, i);
      e_mask[col] = 1'b1;
      col = (col + 1) % len;
    end
    do_stop();
  endtask

  task automatic cmp_commit(string req, logic [AW-1:0] base, logic c);
    chk(s_cnt == 1, req, "commit count", s_cnt, 1);
    chk(s_mask == e_mask, req, "mask", s_mask, e_mask);
    chk(s_addr == base, req, "commit addr", s_addr, base);
    chk(s_ctrl == c, req, "commit target", s_ctrl, c);
    for (int k = 0; k < NB; k++)
      if (e_mask[k]) chk(s_data[8*k +: 8] == e_data[k], req, "data byte",
                         s_data[8*k +: 8], e_data[k]);
  endtask

  task automatic t_reset();
    chk(commit_vld == 0, "R1", "commit_vld", commit_vld, 0);
    chk(ptr_out == 0, "R1", "ptr", ptr_out, 0);
  endtask

  task automatic t_single();
    run_write(12'h123, 0, 1, 8'h5A);
    cmp_commit("R5", 12'h120, 0);
    chk(ptr_out == 12'h124, "R3", "ptr", ptr_out, 12'h124);
  endtask

  task automatic t_wrap12();
    run_write(12'h20A, 0, 12, 8'h11);
    cmp_commit("R3", 12'h200, 0);
    chk(ptr_out == 12'h206, "R3", "ptr", ptr_out, 12'h206);
  endtask

  task automatic t_overflow();
    run_write(12'h340, 0, 20, 8'h80);
    cmp_commit("R4", 12'h340, 0);
    chk(s_data[7:0] == val(8'h80, 16), "R4", "col0 last writer", s_data[7:0], val(8'h80, 16));
    chk(ptr_out == 12'h344, "R4", "ptr", ptr_out, 12'h344);
  endtask

  task automatic t_ctrl_wrap();
    run_write(12'h015, 1, 5, 8'h21);
    cmp_commit("R2", 12'h010, 1);
    chk(s_mask == 16'h00E3, "R2", "ctrl mask", s_mask, 16'h00E3);
    chk(ptr_out == 12'h012, "R2", "ptr", ptr_out, 12'h012);
  endtask

  task automatic t_empty_stop();
    open_txn(12'h400, 0);
    do_stop();
    chk(s_cnt == 0, "R6", "commit count", s_cnt, 0);
  endtask

  task automatic t_abort();
    open_txn(12'h100, 0);
    put(8'h01); put(8'h02); put(8'h03);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    @(negedge clk);
    chk(s_cnt == 0, "R7", "commit after abort", s_cnt, 0);
    do_stop();
    chk(s_cnt == 0, "R7", "commit after abort+stop", s_cnt, 0);
  endtask

  task automatic t_rtc();
    run_write(12'h031, 1, 3, 8'h40);
    chk(s_cnt == 0, "R8", "partial rtc commit", s_cnt, 0);
    run_write(12'h032, 1, 9, 8'h60);
    cmp_commit("R8", 12'h030, 1);
    chk(s_data[23:16] == val(8'h60, 8), "R8", "col2 data", s_data[23:16], val(8'h60, 8));
    chk(ptr_out == 12'h033, "R8", "ptr", ptr_out, 12'h033);
  endtask

  task automatic t_clear_after_commit();
    run_write(12'h500, 0, 2, 8'h33);
    cmp_commit("R9", 12'h500, 0);
    s_cnt = 0;
    do_stop();
    chk(s_cnt == 0, "R9", "second stop commit", s_cnt, 0);
  endtask

  task automatic t_collide();
    open_txn(12'h600, 0);
    put(8'hAA);
    @(negedge clk); stop = 1; byte_vld = 1; byte_data = 8'hBB;
    @(negedge clk); stop = 0; byte_vld = 0;
    @(negedge clk);
    chk(s_cnt == 1, "R10", "commit count", s_cnt, 1);
    chk(s_mask == 16'h0001, "R10", "mask", s_mask, 16'h0001);
    chk(ptr_out == 12'h601, "R10", "ptr", ptr_out, 12'h601);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_wrap12();
    t_overflow();
    t_ctrl_wrap();
    t_empty_stop();
    t_abort();
    t_rtc();
    t_clear_after_commit();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule